// File: doc/BRIEF.md
# ATA Task-File Register Bank

This block holds the host-visible parameter registers of an ATA-style drive controller. The host reaches them through 8-bit accesses. Each access is qualified by a chip-select, a 3-bit register offset and separate write and read strobes. The bank holds six registers: a command parameter byte, a sector count, a sector number, the low and high halves of the cylinder, and a drive/head byte.

On the device side, the bank presents the start address in two views. One is a 28-bit logical block address. The other is the cylinder, head and sector fields. The bank also gives the drive selection and the addressing mode.

The bank keeps a 9-bit count of the sectors still to be moved. Each sector-done pulse from the device side lowers this count. When the command ends, the bank updates the sector count register. On success the register becomes zero. On failure it holds the number of sectors still outstanding.

Top module: `ata_taskfile_regs`

## Requirements
- R1: After synchronous reset, offsets 1 to 5 read 0x00, offset 6 reads 0xA0, `feature` is 0x00 and `remaining` is 0.
- R2: A write (`cs` & `wr_stb` & !`busy`) stores `wdata` at these offsets: 1 parameter, 2 sector count, 3 sector number, 4 cylinder low, 5 cylinder high, 6 drive/head. A read (`cs` & `rd_stb`) of offsets 2 to 5 returns the stored byte. Reads of offsets 0, 1 and 7 return 0x00, and `rdata` is 0x00 when no read is strobed.
- R3: `feature` presents the last byte written at offset 1.
- R4: A write at offset 2 loads `remaining` with the written value, where 0 is loaded as 256.
- R5: Each cycle with `sect_done` high lowers `remaining` by one. A pulse when `remaining` is already 0 leaves it at 0.
- R6: `cmd_end` with `cmd_ok` high makes offset 2 read 0x00 and `remaining` become 0.
- R7: `cmd_end` with `cmd_ok` low makes offset 2 read the low 8 bits of the outstanding count, and `remaining` keeps that count.
- R8: Offset 6 always reads with bit 7 and bit 5 set, whatever was written there.
- R9: `lba` is {drive/head[3:0], cylinder high, cylinder low, sector number}.
- R10: `lba_mode` is drive/head bit 6 (1 = LBA, 0 = CHS). `drive_sel` is bit 4 (1 = slave). `head` is bits 3:0, `cyl` is {cylinder high, cylinder low}, and `sector` is the sector number.
- R11: While `busy` is high, host writes change no register and do not change `remaining`.
- R12: When `sect_done` and `cmd_end` fall in the same cycle, the decrement is applied first, and the completion report uses the decremented count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Host chip-select |
| addr | input | 3 | Register offset |
| wr_stb | input | 1 | Host write strobe |
| rd_stb | input | 1 | Host read strobe |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data (combinational) |
| busy | input | 1 | Command in progress; blocks host writes |
| sect_done | input | 1 | One-cycle pulse per finished sector |
| cmd_end | input | 1 | One-cycle pulse at command completion |
| cmd_ok | input | 1 | Completion outcome, sampled with cmd_end |
| feature | output | 8 | Command parameter byte |
| lba | output | 28 | Assembled logical block address |
| cyl | output | 16 | Cylinder number |
| head | output | 4 | Head number |
| sector | output | 8 | Sector number |
| drive_sel | output | 1 | 0 master, 1 slave |
| lba_mode | output | 1 | 1 LBA addressing, 0 CHS |
| remaining | output | 9 | Live count of sectors still to transfer |

## Verification
Two events can land in the same clock edge: the last sector-done pulse and the completion pulse. In that case the report must include the decrement. The bench provokes this by raising `sect_done` and `cmd_end` together. It does so once after a normal load, with both outcomes. It also does so from a loaded count of 256, where the failed report wraps to 0xFF. It then judges the sector-count readback and `remaining` against the count computed in the bench as load minus pulses.

// File: rtl/tf_pkg.sv
package tf_pkg;
    localparam int DW     = 8;
    localparam int AW     = 3;
    localparam int CNT_W  = DW + 1;
    localparam int HEAD_W = 4;
    localparam int LBA_W  = 3 * DW + HEAD_W;
    localparam int CYL_W  = 2 * DW;

    localparam logic [DW-1:0] DH_RESET = 8'hA0;
    localparam logic [DW-1:0] DH_ONES  = 8'hA0;

    typedef enum logic [AW-1:0] {
        OFS_NONE  = 3'd0,
        OFS_PARAM = 3'd1,
        OFS_COUNT = 3'd2,
        OFS_SNUM  = 3'd3,
        OFS_CYLLO = 3'd4,
        OFS_CYLHI = 3'd5,
        OFS_DRHD  = 3'd6,
        OFS_SPARE = 3'd7
    } tf_ofs_e;

    typedef struct packed {
        logic [LBA_W-1:0]  lba;
        logic [CYL_W-1:0]  cyl;
        logic [HEAD_W-1:0] head;
        logic [DW-1:0]     sector;
        logic              drive;
        logic              lba_mode;
    } tf_view_t;

    function automatic logic [CNT_W-1:0] count_decode(input logic [DW-1:0] v);
        return (v == '0) ? CNT_W'(1 << DW) : {1'b0, v};
    endfunction
endpackage

// File: rtl/tf_count.sv
module tf_count
    import tf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DW-1:0]    ld_val,
    input  logic             dec,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic [DW-1:0]    rpt
);
    logic [CNT_W-1:0] cnt_q, cnt_nxt;

    always_comb begin
        cnt_nxt = cnt_q;
        if (load)
            cnt_nxt = count_decode(ld_val);
        else if (clr)
            cnt_nxt = '0;
        else if (dec && cnt_q != '0)
            cnt_nxt = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_nxt;
    end

    assign cnt = cnt_q;
    assign rpt = cnt_nxt[DW-1:0];

    // R5
    dec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (dec && !load && !clr && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R5
    zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dec && !load && !clr && cnt_q == '0) |=> (cnt_q == '0));

    // R4
    load_val_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q != '0 && cnt_q <= CNT_W'(1 << DW)));
endmodule

// File: rtl/tf_addr_view.sv
module tf_addr_view
    import tf_pkg::*;
(
    input  logic [DW-1:0] snum,
    input  logic [DW-1:0] cyl_lo,
    input  logic [DW-1:0] cyl_hi,
    input  logic [DW-1:0] drhd,
    output tf_view_t      view
);
    always_comb begin
        view.lba      = {drhd[HEAD_W-1:0], cyl_hi, cyl_lo, snum};
        view.cyl      = {cyl_hi, cyl_lo};
        view.head     = drhd[HEAD_W-1:0];
        view.sector   = snum;
        view.drive    = drhd[4];
        view.lba_mode = drhd[6];
    end
endmodule

// File: rtl/ata_taskfile_regs.sv
module ata_taskfile_regs
    import tf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic [AW-1:0]     addr,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic              busy,
    input  logic              sect_done,
    input  logic              cmd_end,
    input  logic              cmd_ok,
    output logic [DW-1:0]     feature,
    output logic [LBA_W-1:0]  lba,
    output logic [CYL_W-1:0]  cyl,
    output logic [HEAD_W-1:0] head,
    output logic [DW-1:0]     sector,
    output logic              drive_sel,
    output logic              lba_mode,
    output logic [CNT_W-1:0]  remaining
);
    tf_ofs_e       ofs;
    logic          wr_en, wr_cnt;
    logic [DW-1:0] par_q, cnt_q, snum_q, clo_q, chi_q, dh_q;
    logic [DW-1:0] rpt;
    tf_view_t      view;

    assign ofs    = tf_ofs_e'(addr);
    assign wr_en  = cs && wr_stb && !busy;
    assign wr_cnt = wr_en && ofs == OFS_COUNT;

    always_ff @(posedge clk) begin
        if (rst) begin
            par_q  <= '0;
            cnt_q  <= '0;
            snum_q <= '0;
            clo_q  <= '0;
            chi_q  <= '0;
            dh_q   <= DH_RESET;
        end else begin
            if (wr_en) begin
                case (ofs)
                    OFS_PARAM: par_q  <= wdata;
                    OFS_SNUM:  snum_q <= wdata;
                    OFS_CYLLO: clo_q  <= wdata;
                    OFS_CYLHI: chi_q  <= wdata;
                    OFS_DRHD:  dh_q   <= wdata | DH_ONES;
                    default: ;
                endcase
            end
            if (wr_cnt)
                cnt_q <= wdata;
            else if (cmd_end)
                cnt_q <= rpt;
        end
    end

    tf_count u_count (
        .clk    (clk),
        .rst    (rst),
        .load   (wr_cnt),
        .ld_val (wdata),
        .dec    (sect_done),
        .clr    (cmd_end && cmd_ok),
        .cnt    (remaining),
        .rpt    (rpt)
    );

    tf_addr_view u_view (
        .snum   (snum_q),
        .cyl_lo (clo_q),
        .cyl_hi (chi_q),
        .drhd   (dh_q),
        .view   (view)
    );

    always_comb begin
        rdata = '0;
        if (cs && rd_stb) begin
            case (ofs)
                OFS_COUNT: rdata = cnt_q;
                OFS_SNUM:  rdata = snum_q;
                OFS_CYLLO: rdata = clo_q;
                OFS_CYLHI: rdata = chi_q;
                OFS_DRHD:  rdata = dh_q;
                default:   rdata = '0;
            endcase
        end
    end

    assign feature   = par_q;
    assign lba       = view.lba;
    assign cyl       = view.cyl;
    assign head      = view.head;
    assign sector    = view.sector;
    assign drive_sel = view.drive;
    assign lba_mode  = view.lba_mode;

    // R8
    dh_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (dh_q[7] && dh_q[5]));

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(lba) && $stable(feature) && $stable(lba_mode) && $stable(drive_sel)));

    // R6
    ok_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_end && cmd_ok && !wr_cnt) |=> (cnt_q == '0 && remaining == '0));

    // R7
    fail_rpt_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_end && !cmd_ok && !wr_cnt) |=> (cnt_q == remaining[DW-1:0]));
endmodule

// File: tb/sim_ata_taskfile_regs.sv
module sim_ata_taskfile_regs;
    localparam int CLK_P = 10;

    logic        clk = 0, rst = 1;
    logic        cs = 0, wr_stb = 0, rd_stb = 0, busy = 0;
    logic [2:0]  addr = 0;
    logic [7:0]  wdata = 0, rdata;
    logic        sect_done = 0, cmd_end = 0, cmd_ok = 0;
    logic [7:0]  feature, sector;
    logic [27:0] lba;
    logic [15:0] cyl;
    logic [3:0]  head;
    logic        drive_sel, lba_mode;
    logic [8:0]  remaining;

    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    ata_taskfile_regs u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); cs = 1; wr_stb = 1; addr = a; wdata = d;
        @(negedge clk); cs = 0; wr_stb = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); cs = 1; rd_stb = 1; addr = a;
        #1 d = rdata;
        cs = 0; rd_stb = 0;
    endtask

    task automatic pulse(input bit dn, input bit en, input bit ok);
        @(negedge clk); sect_done = dn; cmd_end = en; cmd_ok = ok;
        @(negedge clk); sect_done = 0; cmd_end = 0; cmd_ok = 0;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        for (int a = 1; a <= 5; a++) begin rd(3'(a), r); chk("R1", r, 0); end
        rd(6, r); chk("R1", r, 8'hA0);
        chk("R1", feature, 0);
        chk("R1", remaining, 0);
        // R2, R3 parameter register: write-only, output follows
        wr(1, 8'h5A); rd(1, r); chk("R2", r, 0); chk("R3", feature, 8'h5A);
        rd(0, r); chk("R2", r, 0);
        rd(7, r); chk("R2", r, 0);
        // R4 full sweep of count loads
        for (int v = 0; v < 256; v++) begin
            wr(2, 8'(v));
            chk("R4", remaining, (v == 0) ? 256 : v);
            rd(2, r); chk("R2", r, v);
        end
        // R9, R2 address bytes
        for (int k = 0; k < 16; k++) begin
            logic [7:0] s, l, h, d;
            s = 8'(k * 17 + 3); l = 8'(k * 29 + 1); h = 8'(255 - k * 13); d = 8'(k);
            wr(3, s); wr(4, l); wr(5, h); wr(6, d);
            chk("R9", lba, {d[3:0], h, l, s});
            chk("R10", cyl, {h, l});
            chk("R10", sector, s);
            rd(3, r); chk("R2", r, s);
            rd(4, r); chk("R2", r, l);
            rd(5, r); chk("R2", r, h);
        end
        // R8, R10 drive/head sweep
        for (int v = 0; v < 256; v++) begin
            wr(6, 8'(v));
            rd(6, r); chk("R8", r, 8'(v) | 8'hA0);
            chk("R10", lba_mode, (v >> 6) & 1);
            chk("R10", drive_sel, (v >> 4) & 1);
            chk("R10", head, v & 15);
            chk("R9", lba[27:24], v & 15);
        end
        // R5 decrement and floor at zero
        wr(2, 3);
        for (int i = 2; i >= 0; i--) begin pulse(1, 0, 0); chk("R5", remaining, i); end
        pulse(1, 0, 0); chk("R5", remaining, 0);
        wr(2, 0); pulse(1, 0, 0); chk("R5", remaining, 255);
        // R6 success
        wr(2, 10); busy = 1; pulse(1, 0, 0); pulse(1, 0, 0); pulse(0, 1, 1);
        rd(2, r); chk("R6", r, 0); chk("R6", remaining, 0);
        // R7 failure
        busy = 0; wr(2, 10); busy = 1;
        repeat (3) pulse(1, 0, 0);
        pulse(0, 1, 0);
        rd(2, r); chk("R7", r, 7); chk("R7", remaining, 7);
        busy = 0; wr(2, 0); busy = 1; pulse(0, 1, 0);
        rd(2, r); chk("R7", r, 0); chk("R7", remaining, 256);
        // R12 coincident sector-done and end
        busy = 0; wr(2, 5); busy = 1; pulse(1, 1, 0);
        rd(2, r); chk("R12", r, 4); chk("R12", remaining, 4);
        busy = 0; wr(2, 0); busy = 1; pulse(1, 1, 0);
        rd(2, r); chk("R12", r, 8'hFF); chk("R12", remaining, 255);
        busy = 0; wr(2, 5); busy = 1; pulse(1, 1, 1);
        rd(2, r); chk("R12", r, 0); chk("R12", remaining, 0);
        // R11 writes ignored while busy
        busy = 0;
        wr(1, 8'h11); wr(2, 8'h22); wr(3, 8'h33); wr(4, 8'h44); wr(5, 8'h55); wr(6, 8'h06);
        busy = 1;
        for (int a = 1; a <= 6; a++) wr(3'(a), 8'hCC);
        chk("R11", feature, 8'h11);
        chk("R11", remaining, 8'h22);
        rd(2, r); chk("R11", r, 8'h22);
        rd(3, r); chk("R11", r, 8'h33);
        rd(4, r); chk("R11", r, 8'h44);
        rd(5, r); chk("R11", r, 8'h55);
        rd(6, r); chk("R11", r, 8'hA6);
        chk("R11", lba, 28'h6554433);
        busy = 0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule